// File: doc/BRIEF.md
# Serial Port Modem Handshake Unit

This block is the handshake side of a classic asynchronous serial port. A CPU writes a control byte that sets two active-low handshake outputs (terminal ready and request to send). The same byte holds a spare flag bit, a gate for the port's interrupt pin and a switch that turns on an internal loopback for self-test. A status byte shows the present level of the four incoming handshake lines. It also holds four change flags, which stay set until software reads the status byte. A scratch byte and the port's interrupt-enable byte are kept here too.

The incoming lines pass through a synchronizer before any edge is detected. When any change flag is set and the modem-status enable is on, the unit raises a modem-status request. The interrupt pin carries that request only while the control byte's gate bit is set. In loopback the handshake outputs and the serial output are parked high and the external inputs are ignored. The transmit stream is fed straight back to the receive path, and the control bits take the place of the four modem inputs. Writing those control bits therefore produces change flags and interrupts just as external line activity would.

Top module: `modem_ctl_unit`

## Requirements
- R1: After reset every register reads 0, `dtrN` and `rtsN` are 1, no change flag is set, `irqOut` is 0 and `irqOe` is 1.
- R2: Register select 1 is the control byte. Bit 0 drives `dtrN` inverted and bit 1 drives `rtsN` inverted. Bit 2 is a read/write spare flag, bit 3 gates the interrupt pin and bit 4 selects loopback. Bits 7 to 5 read 0.
- R3: Register select 0 is the interrupt-enable byte. Bits 3 to 0 are read/write and appear on `intEnBits`, with bit 3 the modem-status enable. Bits 7 to 4 read 0. Select 2 is the status byte and select 3 is the scratch byte.
- R4: Outside loopback, status bits 4, 5, 6 and 7 read the complement of `ctsN`, `dsrN`, `riN` and `dcdN`. A pin change shows there two clock edges after it is applied.
- R5: Status bits 0, 1 and 3 latch to 1 when the clear-to-send, data-set-ready or carrier-detect line changes in either direction. The flag is visible three edges after the pin change.
- R6: Status bit 2 latches only when `riN` goes from low to high. A high-to-low change of `riN` sets no flag.
- R7: A status read clears bits 3 to 0 at the clock edge of the read. A change detected in the same cycle as the read leaves its flag set.
- R8: `modemIntPending` is 1 when any of status bits 3 to 0 is 1 and enable bit 3 is 1. `irqOut` is `modemIntPending` gated by control bit 3. Clearing the enable hides the request, but the status flags keep updating.
- R9: In loopback `serialOut` is 1, `rxSerial` follows `txSerial`, and `serialIn` has no effect. Outside loopback `serialOut` follows `txSerial` and `rxSerial` follows `serialIn`.
- R10: In loopback `dtrN`, `rtsN` are 1, `irqOe` is 0 and the four modem pins are ignored. The status lines come from the control bits: bit 1 feeds bit 4, bit 0 feeds bit 5, bit 2 feeds bit 6 and bit 3 feeds bit 7. These lines set change flags by the rules of R5 and R6.
- R11: The scratch byte holds any 8-bit value and has no effect on other registers or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuSel | input | 1 | Register access select |
| cpuWr | input | 1 | Write strobe |
| cpuRd | input | 1 | Read strobe (a status read clears flags) |
| cpuAddr | input | 2 | Register select |
| cpuWrData | input | 8 | Write data |
| cpuRdData | output | 8 | Read data for the selected register |
| ctsN | input | 1 | Clear-to-send pin, active low |
| dsrN | input | 1 | Data-set-ready pin, active low |
| riN | input | 1 | Ring pin, active low |
| dcdN | input | 1 | Carrier-detect pin, active low |
| dtrN | output | 1 | Terminal-ready pin, active low |
| rtsN | output | 1 | Request-to-send pin, active low |
| txSerial | input | 1 | Serial stream from the transmitter |
| rxSerial | output | 1 | Serial stream to the receiver |
| serialIn | input | 1 | Serial input pin |
| serialOut | output | 1 | Serial output pin |
| intEnBits | output | 4 | Interrupt-enable bits for the port's other sources |
| modemIntPending | output | 1 | Modem-status request, qualified by its enable |
| irqOut | output | 1 | Interrupt pin value |
| irqOe | output | 1 | Interrupt pin drive enable |

## Verification
The hardest case to reach is a line change whose detection falls in the same cycle as a status read. The flag must survive that read. The stimulus moves a pin, waits exactly two edges so that the synchronized value has arrived but the flag has not yet latched, and then issues the read. A second read must then show the flag. Loopback is reached by writing control bytes that switch the status sources. Toggling the spare bit off then creates a trailing ring edge with no pin activity.

// File: rtl/mcu_pkg.sv
package mcu_pkg;
  localparam int REG_W = 8;
  localparam int LINES = 4;

  typedef enum logic [1:0] {
    SEL_IER = 2'd0,
    SEL_MCR = 2'd1,
    SEL_MSR = 2'd2,
    SEL_SCR = 2'd3
  } regSel_e;

  typedef struct packed {
    logic wrIer;
    logic wrMcr;
    logic wrScr;
    logic rdMsr;
  } regStrobe_t;

  // control byte bit positions
  localparam int MC_DTR  = 0;
  localparam int MC_RTS  = 1;
  localparam int MC_OUT1 = 2;
  localparam int MC_IRQG = 3;
  localparam int MC_LOOP = 4;
  localparam int MC_W    = 5;

  // line index: 0 clear-to-send, 1 data-set-ready, 2 ring, 3 carrier
  localparam int LN_CTS = 0;
  localparam int LN_DSR = 1;
  localparam int LN_RI  = 2;
  localparam int LN_DCD = 3;
endpackage

// File: rtl/mcu_ctrl.sv
module mcu_ctrl
  import mcu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuSel,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic [1:0] cpuAddr,
  output regStrobe_t strobes,
  output regSel_e    rdSel
);
  regSel_e addrSel;
  logic    wrAct;
  logic    rdAct;

  always_comb begin
    addrSel = regSel_e'(cpuAddr);
    wrAct   = cpuSel && cpuWr;
    rdAct   = cpuSel && cpuRd && !cpuWr;
    strobes.wrIer = wrAct && (addrSel == SEL_IER);
    strobes.wrMcr = wrAct && (addrSel == SEL_MCR);
    strobes.wrScr = wrAct && (addrSel == SEL_SCR);
    strobes.rdMsr = rdAct && (addrSel == SEL_MSR);
    rdSel = addrSel;
  end

  // R3: at most one register strobe per cycle
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0(strobes));
endmodule

// File: rtl/mcu_datapath.sv
module mcu_datapath
  import mcu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic             clk,
  input  logic             rst,
  input  regStrobe_t       strobes,
  input  regSel_e          rdSel,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic [LINES-1:0] pinsN,
  output logic             dtrN,
  output logic             rtsN,
  input  logic             txSerial,
  output logic             rxSerial,
  input  logic             serialIn,
  output logic             serialOut,
  output logic [LINES-1:0] intEnBits,
  output logic             modemIntPending,
  output logic             irqOut,
  output logic             irqOe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][LINES-1:0] syncChain;
  logic [MC_W-1:0]  mcr;
  logic [LINES-1:0] ier;
  logic [REG_W-1:0] scr;
  logic [LINES-1:0] prevState;
  logic [LINES-1:0] changeFlags;
  logic [LINES-1:0] extActive;
  logic [LINES-1:0] loopActive;
  logic [LINES-1:0] lineState;
  logic [LINES-1:0] changeEv;
  logic             loopOn;

  // input synchronizer; reset loads the live pin levels
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk) syncChain[0] <= pinsN;
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncChain[s] <= pinsN;
          else     syncChain[s] <= syncChain[s-1];
        end
      end
    end
  endgenerate

  // control, enable and scratch registers
  always_ff @(posedge clk) begin
    if (rst) begin
      mcr <= '0;
      ier <= '0;
      scr <= '0;
    end else begin
      if (strobes.wrMcr) mcr <= wrData[MC_W-1:0];
      if (strobes.wrIer) ier <= wrData[LINES-1:0];
      if (strobes.wrScr) scr <= wrData;
    end
  end

  always_comb begin
    loopOn              = mcr[MC_LOOP];
    extActive           = ~syncChain[LAST];
    loopActive[LN_CTS]  = mcr[MC_RTS];
    loopActive[LN_DSR]  = mcr[MC_DTR];
    loopActive[LN_RI]   = mcr[MC_OUT1];
    loopActive[LN_DCD]  = mcr[MC_IRQG];
    lineState           = loopOn ? loopActive : extActive;
    changeEv[LN_CTS]    = lineState[LN_CTS] ^ prevState[LN_CTS];
    changeEv[LN_DSR]    = lineState[LN_DSR] ^ prevState[LN_DSR];
    changeEv[LN_DCD]    = lineState[LN_DCD] ^ prevState[LN_DCD];
    changeEv[LN_RI]     = prevState[LN_RI] & ~lineState[LN_RI];
  end

  // change flags: a read clears, a fresh event wins over the clear
  always_ff @(posedge clk) begin
    if (rst) begin
      prevState   <= ~pinsN;
      changeFlags <= '0;
    end else begin
      prevState   <= lineState;
      changeFlags <= (strobes.rdMsr ? '0 : changeFlags) | changeEv;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_IER: rdData = {{(REG_W-LINES){1'b0}}, ier};
      SEL_MCR: rdData = {{(REG_W-MC_W){1'b0}}, mcr};
      SEL_MSR: rdData = {lineState, changeFlags};
      SEL_SCR: rdData = scr;
      default: rdData = '0;
    endcase
  end

  always_comb begin
    dtrN            = loopOn | ~mcr[MC_DTR];
    rtsN            = loopOn | ~mcr[MC_RTS];
    serialOut       = loopOn | txSerial;
    rxSerial        = loopOn ? txSerial : serialIn;
    intEnBits       = ier;
    modemIntPending = ier[3] && (|changeFlags);
    irqOut          = modemIntPending && mcr[MC_IRQG];
    irqOe           = !loopOn;
  end

  // R2: a control write without loopback sets the terminal-ready pin inverted
  a_r2_dtr_write: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrMcr && !wrData[MC_LOOP]) |=> (dtrN == !$past(wrData[MC_DTR])));

  // R5: a detected change is latched at the next edge
  a_r5_change_latched: assert property (@(posedge clk) disable iff (rst)
    (|changeEv) |=> ((changeFlags & $past(changeEv)) == $past(changeEv)));

  // R6: ring flag rises only after a trailing ring edge
  a_r6_ring_trailing: assert property (@(posedge clk) disable iff (rst)
    $rose(changeFlags[LN_RI]) |-> $past(prevState[LN_RI] && !lineState[LN_RI]));

  // R7: a read with no new event empties the flags
  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (strobes.rdMsr && (changeEv == '0)) |=> (changeFlags == '0));

  // R8: the pin is only driven by an enabled, gated, pending change
  a_r8_irq_source: assert property (@(posedge clk) disable iff (rst)
    irqOut |-> (ier[3] && (|changeFlags) && mcr[MC_IRQG]));

  // R10: loopback parks the handshake and serial outputs
  a_r10_loop_parks: assert property (@(posedge clk) disable iff (rst)
    mcr[MC_LOOP] |-> (dtrN && rtsN && serialOut && !irqOe));
endmodule

// File: rtl/modem_ctl_unit.sv
module modem_ctl_unit
  import mcu_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpuSel,
  input  logic       cpuWr,
  input  logic       cpuRd,
  input  logic [1:0] cpuAddr,
  input  logic [7:0] cpuWrData,
  output logic [7:0] cpuRdData,
  input  logic       ctsN,
  input  logic       dsrN,
  input  logic       riN,
  input  logic       dcdN,
  output logic       dtrN,
  output logic       rtsN,
  input  logic       txSerial,
  output logic       rxSerial,
  input  logic       serialIn,
  output logic       serialOut,
  output logic [3:0] intEnBits,
  output logic       modemIntPending,
  output logic       irqOut,
  output logic       irqOe
);
  regStrobe_t       strobes;
  regSel_e          rdSel;
  logic [LINES-1:0] pinsN;

  assign pinsN = {dcdN, riN, dsrN, ctsN};

  mcu_ctrl ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .cpuSel  (cpuSel),
    .cpuWr   (cpuWr),
    .cpuRd   (cpuRd),
    .cpuAddr (cpuAddr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  mcu_datapath #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk             (clk),
    .rst             (rst),
    .strobes         (strobes),
    .rdSel           (rdSel),
    .wrData          (cpuWrData),
    .rdData          (cpuRdData),
    .pinsN           (pinsN),
    .dtrN            (dtrN),
    .rtsN            (rtsN),
    .txSerial        (txSerial),
    .rxSerial        (rxSerial),
    .serialIn        (serialIn),
    .serialOut       (serialOut),
    .intEnBits       (intEnBits),
    .modemIntPending (modemIntPending),
    .irqOut          (irqOut),
    .irqOe           (irqOe)
  );
endmodule

// File: tb/modem_ctl_unit_tb_top.sv
module modem_ctl_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cpuSel = 1'b0, cpuWr = 1'b0, cpuRd = 1'b0;
  logic [1:0] cpuAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic [7:0] cpuRdData;
  logic       ctsN = 1'b1, dsrN = 1'b1, riN = 1'b1, dcdN = 1'b1;
  logic       dtrN, rtsN;
  logic       txSerial = 1'b1, serialIn = 1'b1;
  logic       rxSerial, serialOut;
  logic [3:0] intEnBits;
  logic       modemIntPending, irqOut, irqOe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  modem_ctl_unit dut_i (
    .clk(clk), .rst(rst), .cpuSel(cpuSel), .cpuWr(cpuWr), .cpuRd(cpuRd),
    .cpuAddr(cpuAddr), .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .ctsN(ctsN), .dsrN(dsrN), .riN(riN), .dcdN(dcdN),
    .dtrN(dtrN), .rtsN(rtsN), .txSerial(txSerial), .rxSerial(rxSerial),
    .serialIn(serialIn), .serialOut(serialOut), .intEnBits(intEnBits),
    .modemIntPending(modemIntPending), .irqOut(irqOut), .irqOe(irqOe)
  );

  typedef struct packed {
    logic       isWr;
    logic [1:0] addr;
    logic [7:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 14;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 2'd0, 8'hFF, 4'd3},   // R3 enable write
    '{1'b0, 2'd0, 8'h0F, 4'd3},   // R3 upper bits read 0
    '{1'b1, 2'd1, 8'hE4, 4'd2},   // R2 spare bit plus unused bits
    '{1'b0, 2'd1, 8'h04, 4'd2},   // R2 spare bit kept, 7..5 read 0
    '{1'b1, 2'd3, 8'hA5, 4'd11},  // R11
    '{1'b0, 2'd3, 8'hA5, 4'd11},
    '{1'b0, 2'd1, 8'h04, 4'd11},  // R11 control untouched
    '{1'b1, 2'd3, 8'h5A, 4'd11},
    '{1'b0, 2'd3, 8'h5A, 4'd11},
    '{1'b1, 2'd0, 8'h00, 4'd3},
    '{1'b0, 2'd0, 8'h00, 4'd3},
    '{1'b1, 2'd1, 8'h00, 4'd2},
    '{1'b0, 2'd1, 8'h00, 4'd2},
    '{1'b0, 2'd2, 8'h00, 4'd4}    // R4 idle lines read 0
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // tasks start just after a falling edge and end on the next one
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cpuSel = 1'b1; cpuWr = 1'b1; cpuAddr = a; cpuWrData = d;
    @(negedge clk);
    cpuSel = 1'b0; cpuWr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cpuSel = 1'b1; cpuRd = 1'b1; cpuAddr = a;
    #1 d = cpuRdData;
    @(negedge clk);
    cpuSel = 1'b0; cpuRd = 1'b0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    waitn(3);
    rst = 1'b0;
    waitn(1);
    // R1 reset state
    rd(2'd0, rv); chk("R1 ier", rv, 8'h00);
    rd(2'd1, rv); chk("R1 mcr", rv, 8'h00);
    rd(2'd2, rv); chk("R1 msr", rv, 8'h00);
    rd(2'd3, rv); chk("R1 scr", rv, 8'h00);
    chk("R1 dtrN", {7'd0, dtrN}, 8'h01);
    chk("R1 rtsN", {7'd0, rtsN}, 8'h01);
    chk("R1 irqOut", {7'd0, irqOut}, 8'h00);
    chk("R1 irqOe", {7'd0, irqOe}, 8'h01);

    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWr) wr(VECS[i].addr, VECS[i].val);
      else begin
        rd(VECS[i].addr, rv);
        chk($sformatf("R%0d vec%0d", VECS[i].req, i), rv, VECS[i].val);
      end
    end

    // R2 pin polarity
    wr(2'd1, 8'h03);
    chk("R2 dtrN low", {7'd0, dtrN}, 8'h00);
    chk("R2 rtsN low", {7'd0, rtsN}, 8'h00);
    wr(2'd1, 8'h01);
    chk("R2 rtsN high", {7'd0, rtsN}, 8'h01);
    wr(2'd1, 8'h00);
    chk("R11 dtrN after scratch", {7'd0, dtrN}, 8'h01);

    // R9 normal serial routing
    txSerial = 1'b0; serialIn = 1'b1; #1;
    chk("R9 serialOut follows tx", {7'd0, serialOut}, 8'h00);
    chk("R9 rx follows serialIn", {7'd0, rxSerial}, 8'h01);
    txSerial = 1'b1;
    waitn(1);

    // R4 R5 clear-to-send falls
    ctsN = 1'b0; waitn(3);
    rd(2'd2, rv); chk("R5 cts delta", rv, 8'h11);
    rd(2'd2, rv); chk("R7 read clears", rv, 8'h10);
    dcdN = 1'b0; waitn(3);
    rd(2'd2, rv); chk("R5 dcd delta", rv, 8'h98);
    rd(2'd2, rv); chk("R7 dcd cleared", rv, 8'h90);
    // R6 ring leading edge: no flag
    riN = 1'b0; waitn(3);
    rd(2'd2, rv); chk("R6 ring start no flag", rv, 8'hD0);
    riN = 1'b1; waitn(3);
    rd(2'd2, rv); chk("R6 ring trailing flag", rv, 8'h94);
    rd(2'd2, rv); chk("R6 ring cleared", rv, 8'h90);
    dsrN = 1'b0; waitn(3);
    rd(2'd2, rv); chk("R5 dsr delta", rv, 8'hB2);
    ctsN = 1'b1; dsrN = 1'b1; dcdN = 1'b1; waitn(3);
    rd(2'd2, rv); chk("R5 release deltas", rv, 8'h0B);
    rd(2'd2, rv); chk("R7 idle", rv, 8'h00);

    // R8 interrupt qualification
    wr(2'd0, 8'h08); wr(2'd1, 8'h08);
    chk("R3 intEnBits", {4'd0, intEnBits}, 8'h08);
    ctsN = 1'b0; waitn(3);
    chk("R8 irq raised", {7'd0, irqOut}, 8'h01);
    chk("R8 pending", {7'd0, modemIntPending}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R8 enable off hides pending", {7'd0, modemIntPending}, 8'h00);
    chk("R8 enable off irq", {7'd0, irqOut}, 8'h00);
    rd(2'd2, rv); chk("R8 flags still update", rv, 8'h11);
    wr(2'd0, 8'h08);
    chk("R8 no flag no irq", {7'd0, irqOut}, 8'h00);
    ctsN = 1'b1; waitn(3);
    chk("R8 irq again", {7'd0, irqOut}, 8'h01);
    wr(2'd1, 8'h00);
    chk("R8 gate off irq", {7'd0, irqOut}, 8'h00);
    chk("R8 gate off pending", {7'd0, modemIntPending}, 8'h01);
    rd(2'd2, rv); chk("R8 flag view", rv, 8'h01);
    chk("R8 read drops pending", {7'd0, modemIntPending}, 8'h00);

    // R7 change coincident with read
    ctsN = 1'b0; waitn(2);
    rd(2'd2, rv); chk("R7 coincident read", rv, 8'h10);
    rd(2'd2, rv); chk("R7 event kept", rv, 8'h11);
    rd(2'd2, rv); chk("R7 then cleared", rv, 8'h10);
    ctsN = 1'b1; waitn(3);
    rd(2'd2, rv); chk("R5 cts rise", rv, 8'h01);

    // R9 R10 loopback
    wr(2'd1, 8'h10);
    txSerial = 1'b0; serialIn = 1'b1; #1;
    chk("R9 loop serialOut mark", {7'd0, serialOut}, 8'h01);
    chk("R9 loop rx from tx", {7'd0, rxSerial}, 8'h00);
    txSerial = 1'b1; serialIn = 1'b0; #1;
    chk("R9 loop serialIn ignored", {7'd0, rxSerial}, 8'h01);
    chk("R10 irqOe off", {7'd0, irqOe}, 8'h00);
    waitn(1);
    rd(2'd2, rv); chk("R10 loop idle", rv, 8'h00);
    wr(2'd1, 8'h1F);
    chk("R10 dtrN parked", {7'd0, dtrN}, 8'h01);
    chk("R10 rtsN parked", {7'd0, rtsN}, 8'h01);
    waitn(1);
    rd(2'd2, rv); chk("R10 loop mapping", rv, 8'hFB);
    rd(2'd2, rv); chk("R10 loop cleared", rv, 8'hF0);
    ctsN = 1'b0; dcdN = 1'b0; waitn(3);
    rd(2'd2, rv); chk("R10 pins ignored", rv, 8'hF0);
    wr(2'd1, 8'h1B);
    waitn(1);
    rd(2'd2, rv); chk("R10 loop ring trailing", rv, 8'hB4);
    wr(2'd1, 8'h1D);
    waitn(1);
    rd(2'd2, rv); chk("R10 rts to cts, out1 to ri", rv, 8'hE1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule